// File: doc/BRIEF.md
# Peripheral Interrupt Register Block

The block gathers interrupt requests from four peripherals, each owning up to eight sources, and presents them as one shared interrupt line to a host. Every peripheral gets a 256-byte register window on a simple synchronous register bus. Within each window the host picks, per source, edge or level detection. It can also arm the high/rising sense, the low/falling sense, or both.

Detected events land in a latched status register, which the host clears by writing ones. Sources are enabled and disabled through two separate write addresses, so a single bit can change without a read-modify-write. The four windows sit at unevenly spaced base addresses. A small decoder steers each access to the matching window, and the enabled latched bits of all windows are ORed onto the one output.

Top module: `periph_irq_hub`

## Requirements
- R1: Windows start at 0x0900, 0x2400, 0xC000 and 0xC100 (peripherals 0 to 3), each 256 bytes, selected by address bits 15:8 with the register picked by bits 7:0. Writes outside the four windows change nothing, and reads there return 0. Peripheral p uses source bits [8p+7:8p].
- R2: Offset 0x10 reads the current level of the peripheral's eight source inputs, in the same cycle.
- R3: Offsets 0x11 (mode: 1 = edge, 0 = level), 0x12 (high/rising arm) and 0x13 (low/falling arm) are plain read/write registers with one bit per source.
- R4: In edge mode, a source whose input differs from its value at the previous clock edge sets its latched bit on a rise when the high arm is set, and on a fall when the low arm is set. With both arms set it latches on both edges.
- R5: In level mode, the latched bit is set at every clock edge where the input is 1 with the high arm set, or 0 with the low arm set. Once set, it stays set until cleared.
- R6: Writing ones to offset 0x15 enables those sources, and writing ones to offset 0x16 disables them. Zero bits leave the enable unchanged. Both offsets read back the enable mask.
- R7: Writing ones to offset 0x14 clears those latched bits, and the offset reads 0. A clear wins over an event at the same edge, so a level source whose armed level persists latches again one edge later.
- R8: Offset 0x18 reads the latched status, which is recorded whether or not the source is enabled. Unlisted offsets read 0.
- R9: The output is 1 exactly when some peripheral has a latched bit whose enable is also set.
- R10: After reset, every register is 0 and the output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Register address |
| we_i | input | 1 | Write strobe, acts at the rising clock edge |
| wdata_i | input | 8 | Write data, one bit per source |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| src_i | input | 32 | Source inputs, eight per peripheral |
| irq_o | output | 1 | Shared interrupt output |

## Verification
Some properties are checked on every cycle. The live-status read must always match the inputs. An enable-set or enable-clear write must show in the following read-back. A latched bit may only rise after a detected event, and a clear must drop its bits unless an event arrived at the same edge. The output must stay low while no enabled latched bit exists. The detection rules cannot be expressed that way: rising, falling and dual-edge capture, level re-latching after a clear, the uneven base addresses and writes to unmapped space. Those are shown by the bench's directed sequences and its randomized traffic, which is compared against a cycle-accurate bench model.

// File: rtl/periph_irq_pkg.sv
package periph_irq_pkg;
  localparam int N_PERIPH = 4;
  localparam int ADDR_W   = 16;
  localparam int WIN_W    = 8;

  localparam logic [WIN_W-1:0] OFF_LIVE   = 8'h10;
  localparam logic [WIN_W-1:0] OFF_MODE   = 8'h11;
  localparam logic [WIN_W-1:0] OFF_ARM_HI = 8'h12;
  localparam logic [WIN_W-1:0] OFF_ARM_LO = 8'h13;
  localparam logic [WIN_W-1:0] OFF_W1C    = 8'h14;
  localparam logic [WIN_W-1:0] OFF_EN_SET = 8'h15;
  localparam logic [WIN_W-1:0] OFF_EN_CLR = 8'h16;
  localparam logic [WIN_W-1:0] OFF_LATCH  = 8'h18;

  function automatic logic [ADDR_W-1:0] win_base(input int p);
    case (p)
      0:       win_base = 16'h0900;
      1:       win_base = 16'h2400;
      2:       win_base = 16'hC000;
      default: win_base = 16'hC100;
    endcase
  endfunction
endpackage

// File: rtl/periph_irq_dec.sv
module periph_irq_dec
  import periph_irq_pkg::*;
#(
  parameter int N_WIN = N_PERIPH
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_WIN-1:0]  sel_o,
  output logic [WIN_W-1:0]  off_o
);
  assign off_o = addr_i[WIN_W-1:0];

  for (genvar p = 0; p < N_WIN; p++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE = win_base(p);
    assign sel_o[p] = (addr_i[ADDR_W-1:WIN_W] == BASE[ADDR_W-1:WIN_W]);
  end
endmodule

// File: rtl/periph_irq_evt.sv
module periph_irq_evt #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] mode_i,
  input  logic [N_SRC-1:0] arm_hi_i,
  input  logic [N_SRC-1:0] arm_lo_i,
  output logic [N_SRC-1:0] evt_o
);
  logic [N_SRC-1:0] src_q, rise, fall, lvl_hit, edge_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i;
  end

  assign rise     = src_i & ~src_q;
  assign fall     = ~src_i & src_q;
  assign edge_hit = (rise & arm_hi_i) | (fall & arm_lo_i);
  assign lvl_hit  = (src_i & arm_hi_i) | (~src_i & arm_lo_i);
  assign evt_o    = (mode_i & edge_hit) | (~mode_i & lvl_hit);
endmodule

// File: rtl/periph_irq_regs.sv
module periph_irq_regs
  import periph_irq_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [WIN_W-1:0] off_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] rdata_o,
  output logic [N_SRC-1:0] lat_o,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] evt_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] mode_q, arm_hi_q, arm_lo_q, en_q, lat_q, clr;
  logic             wr;

  assign wr  = sel_i & we_i;
  assign clr = (wr && off_i == OFF_W1C) ? wdata_i : '0;

  periph_irq_evt #(.N_SRC(N_SRC)) evt_u (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .mode_i   (mode_q),
    .arm_hi_i (arm_hi_q),
    .arm_lo_i (arm_lo_q),
    .evt_o    (evt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      arm_hi_q <= '0;
      arm_lo_q <= '0;
      en_q     <= '0;
      lat_q    <= '0;
    end else begin
      // clear beats a same-edge event
      lat_q <= (lat_q | evt_o) & ~clr;
      if (wr) begin
        case (off_i)
          OFF_MODE:   mode_q   <= wdata_i;
          OFF_ARM_HI: arm_hi_q <= wdata_i;
          OFF_ARM_LO: arm_lo_q <= wdata_i;
          OFF_EN_SET: en_q     <= en_q | wdata_i;
          OFF_EN_CLR: en_q     <= en_q & ~wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (off_i)
        OFF_LIVE:               rdata_o = src_i;
        OFF_MODE:               rdata_o = mode_q;
        OFF_ARM_HI:             rdata_o = arm_hi_q;
        OFF_ARM_LO:             rdata_o = arm_lo_q;
        OFF_EN_SET, OFF_EN_CLR: rdata_o = en_q;
        OFF_LATCH:              rdata_o = lat_q;
        default:                rdata_o = '0;
      endcase
    end
  end

  assign lat_o = lat_q;
  assign en_o  = en_q;
  assign irq_o = |(lat_q & en_q);
endmodule

// File: rtl/periph_irq_hub.sv
module periph_irq_hub
  import periph_irq_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      we_i,
  input  logic [N_SRC-1:0]          wdata_i,
  output logic [N_SRC-1:0]          rdata_o,
  input  logic [N_PERIPH*N_SRC-1:0] src_i,
  output logic                      irq_o
);
  localparam int N_ALL = N_PERIPH * N_SRC;

  logic [N_PERIPH-1:0] sel, irq_u;
  logic [WIN_W-1:0]    off;
  logic [N_SRC-1:0]    rd_u [N_PERIPH];
  logic [N_ALL-1:0]    lat_all, en_all, evt_all;

  periph_irq_dec #(.N_WIN(N_PERIPH)) dec_u (
    .addr_i (addr_i),
    .sel_o  (sel),
    .off_o  (off)
  );

  for (genvar p = 0; p < N_PERIPH; p++) begin : g_unit
    periph_irq_regs #(.N_SRC(N_SRC)) regs_u (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel[p]),
      .we_i    (we_i),
      .off_i   (off),
      .wdata_i (wdata_i),
      .src_i   (src_i[p*N_SRC +: N_SRC]),
      .rdata_o (rd_u[p]),
      .lat_o   (lat_all[p*N_SRC +: N_SRC]),
      .en_o    (en_all[p*N_SRC +: N_SRC]),
      .evt_o   (evt_all[p*N_SRC +: N_SRC]),
      .irq_o   (irq_u[p])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < N_PERIPH; p++) rdata_o = rdata_o | rd_u[p];
  end

  assign irq_o = |irq_u;
endmodule

// File: rtl/periph_irq_hub_chk.sv
module periph_irq_hub_chk
  import periph_irq_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [ADDR_W-1:0]         addr_i,
  input logic                      we_i,
  input logic [N_SRC-1:0]          wdata_i,
  input logic [N_SRC-1:0]          rdata_o,
  input logic [N_PERIPH*N_SRC-1:0] src_i,
  input logic                      irq_o,
  input logic [N_PERIPH*N_SRC-1:0] lat_all,
  input logic [N_PERIPH*N_SRC-1:0] en_all,
  input logic [N_PERIPH*N_SRC-1:0] evt_all
);
  localparam logic [ADDR_W-1:0] P1_LIVE   = win_base(1) | ADDR_W'(OFF_LIVE);
  localparam logic [ADDR_W-1:0] P0_EN_SET = win_base(0) | ADDR_W'(OFF_EN_SET);
  localparam logic [ADDR_W-1:0] P0_EN_CLR = win_base(0) | ADDR_W'(OFF_EN_CLR);
  localparam logic [ADDR_W-1:0] P2_W1C    = win_base(2) | ADDR_W'(OFF_W1C);

  // R2
  live_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == P1_LIVE) |-> (rdata_o == src_i[N_SRC +: N_SRC]));

  // R6
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i && addr_i == P0_EN_SET) && addr_i == P0_EN_SET)
      |-> ((rdata_o & $past(wdata_i)) == $past(wdata_i)));

  // R6
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i && addr_i == P0_EN_CLR) && addr_i == P0_EN_SET)
      |-> ((rdata_o & $past(wdata_i)) == '0));

  // R4
  latch_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_all & ~$past(lat_all) & ~$past(evt_all)) == '0);

  // R7
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && addr_i == P2_W1C)
      |-> ((lat_all[2*N_SRC +: N_SRC] & $past(wdata_i)
            & ~$past(evt_all[2*N_SRC +: N_SRC])) == '0));

  // R9
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lat_all & en_all) == '0) |-> !irq_o);
endmodule

bind periph_irq_hub periph_irq_hub_chk #(.N_SRC(N_SRC)) chk_i (.*);

// File: tb/periph_irq_hub_tb_top.sv
`timescale 1ns/1ps
module periph_irq_hub_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [31:0] src_i = '0;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] s = '0;
  logic [7:0]  last_rd;

  logic [7:0] m_mode [4], m_hi [4], m_lo [4], m_en [4], m_lat [4], m_prev [4];

  always #4 clk_i = ~clk_i;

  periph_irq_hub dut_i (.*);

  function automatic int pidx(input logic [15:0] a);
    case (a[15:8])
      8'h09:   return 0;
      8'h24:   return 1;
      8'hC0:   return 2;
      8'hC1:   return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a, input logic [31:0] sv);
    int p = pidx(a);
    if (p < 0) return 8'h00;
    case (a[7:0])
      8'h10:        return sv[p*8 +: 8];
      8'h11:        return m_mode[p];
      8'h12:        return m_hi[p];
      8'h13:        return m_lo[p];
      8'h15, 8'h16: return m_en[p];
      8'h18:        return m_lat[p];
      default:      return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [15:0] a);
    if (pidx(a) < 0) return "R1";
    case (a[7:0])
      8'h10:               return "R2";
      8'h11, 8'h12, 8'h13: return "R3";
      8'h14:               return "R7";
      8'h15, 8'h16:        return "R6";
      8'h18:               return "R8";
      default:             return "R1";
    endcase
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int p = 0; p < 4; p++) r = r | (|(m_lat[p] & m_en[p]));
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic model_edge(input logic [31:0] sv, input logic w, input logic [15:0] a,
                            input logic [7:0] d);
    int q = pidx(a);
    for (int p = 0; p < 4; p++) begin
      logic [7:0] x, pv, ev, clr;
      x   = sv[p*8 +: 8];
      pv  = m_prev[p];
      ev  = (m_mode[p] & (((x & ~pv) & m_hi[p]) | ((~x & pv) & m_lo[p])))
          | (~m_mode[p] & ((x & m_hi[p]) | (~x & m_lo[p])));
      clr = (w && q == p && a[7:0] == 8'h14) ? d : 8'h00;
      m_lat[p]  = (m_lat[p] | ev) & ~clr;
      m_prev[p] = x;
    end
    if (w && q >= 0) begin
      case (a[7:0])
        8'h11: m_mode[q] = d;
        8'h12: m_hi[q]   = d;
        8'h13: m_lo[q]   = d;
        8'h15: m_en[q]   = m_en[q] | d;
        8'h16: m_en[q]   = m_en[q] & ~d;
        default: ;
      endcase
    end
  endtask

  // one bus cycle: drive at negedge, check reads and irq before the edge
  task automatic step(input logic [31:0] sv, input logic w, input logic [15:0] a,
                      input logic [7:0] d);
    @(negedge clk_i);
    src_i = sv; we_i = w; addr_i = a; wdata_i = d;
    #1;
    last_rd = rdata_o;
    check(req_of(a), rdata_o, exp_rd(a, sv));
    check("R9", {7'd0, irq_o}, {7'd0, exp_irq()});
    @(posedge clk_i);
    model_edge(sv, w, a, d);
  endtask

  task automatic probe(input logic [31:0] sv, input logic [15:0] a, input logic [7:0] e,
                       input string req);
    step(sv, 1'b0, a, 8'h00);
    check(req, last_rd, e);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20461);
    for (int p = 0; p < 4; p++) begin
      m_mode[p] = '0; m_hi[p] = '0; m_lo[p] = '0;
      m_en[p] = '0; m_lat[p] = '0; m_prev[p] = '0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R10 reset state
    probe(s, 16'h0918, 8'h00, "R10");
    probe(s, 16'hC115, 8'h00, "R10");
    check("R10", {7'd0, irq_o}, 8'h00);

    // R4 rising edge on peripheral 0 source 0
    step(s, 1'b1, 16'h0911, 8'h01);
    step(s, 1'b1, 16'h0912, 8'h01);
    step(s, 1'b1, 16'h0915, 8'h01);
    s[0] = 1'b1;
    step(s, 1'b0, 16'h0000, 8'h00);
    probe(s, 16'h0918, 8'h01, "R4");
    check("R9", {7'd0, irq_o}, 8'h01);
    // R7 clear with input held high: edge source stays clear
    step(s, 1'b1, 16'h0914, 8'h01);
    probe(s, 16'h0918, 8'h00, "R7");
    probe(s, 16'h0914, 8'h00, "R7");

    // R4 both edges on peripheral 3 source 7, not enabled
    step(s, 1'b1, 16'hC111, 8'h80);
    step(s, 1'b1, 16'hC112, 8'h80);
    step(s, 1'b1, 16'hC113, 8'h80);
    s[31] = 1'b1;
    step(s, 1'b0, 16'h0000, 8'h00);
    probe(s, 16'hC118, 8'h80, "R4");
    step(s, 1'b1, 16'hC114, 8'h80);
    s[31] = 1'b0;
    step(s, 1'b0, 16'h0000, 8'h00);
    probe(s, 16'hC118, 8'h80, "R4");
    probe(s, 16'hC018, 8'h00, "R1");
    // R8 latched while disabled, output stays low
    check("R8", {7'd0, irq_o}, 8'h00);

    // R6 zero bits have no effect, set/clear read back
    step(s, 1'b1, 16'hC115, 8'h00);
    probe(s, 16'hC115, 8'h00, "R6");
    step(s, 1'b1, 16'hC115, 8'h80);
    probe(s, 16'hC116, 8'h80, "R6");
    step(s, 1'b1, 16'hC116, 8'h00);
    probe(s, 16'hC115, 8'h80, "R6");
    check("R9", {7'd0, irq_o}, 8'h01);
    step(s, 1'b1, 16'hC116, 8'h80);
    probe(s, 16'hC115, 8'h00, "R6");

    // R5 level-low on peripheral 1 source 2, R7 re-latch after clear
    step(s, 1'b1, 16'h2413, 8'h04);
    step(s, 1'b0, 16'h0000, 8'h00);
    probe(s, 16'h2418, 8'h04, "R5");
    step(s, 1'b1, 16'h2414, 8'h04);
    probe(s, 16'h2418, 8'h00, "R7");
    probe(s, 16'h2418, 8'h04, "R7");
    s[10] = 1'b1;
    step(s, 1'b1, 16'h2414, 8'h04);
    probe(s, 16'h2418, 8'h00, "R5");

    // R1 unmapped write ignored
    step(s, 1'b1, 16'h0A11, 8'hFF);
    probe(s, 16'h0911, 8'h01, "R1");
    probe(s, 16'h0A11, 8'h00, "R1");

    // R2 live status
    s[15:8] = 8'hA5;
    probe(s, 16'h2410, 8'hA5, "R2");
    // R3 config read/write
    step(s, 1'b1, 16'hC012, 8'h3C);
    probe(s, 16'hC012, 8'h3C, "R3");

    // randomized traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [7:0]  offs;
      int b = $urandom_range(0, 4);
      case ($urandom_range(0, 10))
        0: offs = 8'h10;  1: offs = 8'h11;  2: offs = 8'h12;  3: offs = 8'h13;
        4: offs = 8'h14;  5: offs = 8'h15;  6: offs = 8'h16;  7: offs = 8'h18;
        8: offs = 8'h17;  9: offs = 8'h00;  default: offs = 8'h14;
      endcase
      case (b)
        0: a = 16'h0900;  1: a = 16'h2400;  2: a = 16'hC000;  3: a = 16'hC100;
        default: a = {8'h30 + 8'($urandom_range(0, 15)), 8'h00};
      endcase
      a[7:0] = offs;
      s = s ^ ($urandom & $urandom & $urandom);
      step(s, 1'($urandom_range(0, 1)), a, 8'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule